// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block paces a serial transmitter and receiver from a single functional clock. The clock is first slowed by a small integer prescaler. The resulting clock enable then drives a fractional divider whose divisor has a 16-bit whole part and a 6-bit fraction. The divider emits a one-cycle oversampling tick. A small counter groups those ticks into a bit-rate strobe: one strobe for every 16, 8 or 3 ticks.

Software works out the prescaler, whole, fraction and oversampling settings for a target baud rate. It loads them while the block is disabled and then raises the enable. The fraction is handled with a 6-bit phase accumulator. Whenever the accumulator wraps, the current tick period is stretched by one prescaled clock, so the long-run tick rate matches the fixed-point divisor exactly. A whole part of zero stops all ticks, whatever the fraction is.

Top module: `baud_tick_gen`

## Requirements
- R1: `presc_sel` value p divides the clock by p+1, for all values 0 to 7. Every tick period is a multiple of p+1 clock cycles.
- R2: Let W be `div_int`, F be `div_frac` and D be p+1. Each tick period is W·D or (W+1)·D cycles. The 64 periods that end at the 64th tick after enable total exactly D·(64·W+F) cycles.
- R3: With D=1, W=130 and F=13, which are the settings for 19200 baud at 16x oversampling from 40 MHz, the tick spacing follows R2.
- R4: When W is zero, no tick and no strobe is produced, for any value of F.
- R5: `bit_strobe` pulses once for every N ticks, on the cycle after the N-th tick of each group. `ovs_sel` 2'b00 gives N=16, 2'b01 gives N=8, 2'b10 gives N=3, and 2'b11 falls back to N=16.
- R6: Enable is sampled on a clock edge. The first tick is seen W·D+1 cycles after that edge. Deasserting enable clears all counters and both outputs, so a fresh enable restarts this same latency.
- R7: The settings are captured only while the block is disabled. A change to `presc_sel`, `div_int`, `div_frac` or `ovs_sel` while enabled has no effect on the tick spacing.
- R8: After synchronous reset, `tick` and `bit_strobe` are low.
- R9: `bit_strobe` is never high in two consecutive cycles. When W·D ≥ 2, `tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; settings are captured while low |
| presc_sel | input | 3 | Prescaler select, divide by value+1 |
| div_int | input | 16 | Whole part of divisor |
| div_frac | input | 6 | Fractional part of divisor, in 1/64 steps |
| ovs_sel | input | 2 | Oversampling select (16x, 8x, 3x) |
| tick | output | 1 | Oversampling tick, one cycle |
| bit_strobe | output | 1 | Bit-rate strobe, once per N ticks |

## Verification
The divider is run with five setting sets. One has no fraction. One has a fraction of exactly one half. One has the largest fraction, 63/64, under the largest prescaler. One has the smallest fraction under a divide-by-2 prescaler. The last is the 40 MHz / 19200 baud case.

Measuring the first-tick latency separates prescaler errors from accumulator errors. Measuring every period, and the 64-tick span, shows whether the stretch lands once per wrap and whether any stretch is lost or doubled. Counting strobes across the 16x, 8x, 3x and reserved encodings checks the grouping. Directed runs then cover a zero whole part, settings changed while running, and restart after a disable.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  typedef enum logic [1:0] {
    OVS_X16 = 2'b00,
    OVS_X8  = 2'b01,
    OVS_X3  = 2'b10,
    OVS_RSV = 2'b11
  } ovs_e;

  localparam int OVS_CNT_W = 5;

  function automatic logic [OVS_CNT_W-1:0] ovs_ratio(input ovs_e sel);
    case (sel)
      OVS_X8:  ovs_ratio = OVS_CNT_W'(8);
      OVS_X3:  ovs_ratio = OVS_CNT_W'(3);
      default: ovs_ratio = OVS_CNT_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int PRESC_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               ce
);

  logic [PRESC_W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      ce   <= 1'b0;
    end else if (pcnt == presc) begin
      pcnt <= '0;
      ce   <= 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
      ce   <= 1'b0;
    end
  end

  // R1: a divide above one leaves a gap after every enable pulse
  p_ce_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (run && ce && presc != '0) |=> !ce);

  // R6: a stopped prescaler produces no enables
  p_ce_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> !ce);

endmodule

// File: rtl/bt_frac_div.sv
module bt_frac_div #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ce,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);

  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [FRAC_W-1:0] phase;
  logic [FRAC_W:0]   phase_sum;
  logic [CNT_W-1:0]  target;
  logic              whole_ok;

  // The stretch for the current period comes from the phase before it is updated.
  assign phase_sum = {1'b0, phase} + {1'b0, div_frac};
  assign target    = {1'b0, div_int} + CNT_W'(phase_sum[FRAC_W]);
  assign whole_ok  = (div_int != '0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      phase <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (ce && whole_ok) begin
        if (cnt + 1'b1 >= target) begin
          cnt   <= '0;
          phase <= phase_sum[FRAC_W-1:0];
          tick  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: a zero whole part never yields a tick
  p_no_tick_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (div_int == '0) |-> !tick);

  // R2: a tick can only follow a prescaled enable
  p_tick_on_ce_r2: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(ce));

endmodule

// File: rtl/bt_ovs_counter.sv
module bt_ovs_counter
  import baud_tick_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  ovs_e ovs,
  output logic strobe
);

  logic [OVS_CNT_W-1:0] ocnt;
  logic [OVS_CNT_W-1:0] last_idx;

  assign last_idx = ovs_ratio(ovs) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ocnt   <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (tick) begin
        if (ocnt >= last_idx) begin
          ocnt   <= '0;
          strobe <= 1'b1;
        end else begin
          ocnt <= ocnt + 1'b1;
        end
      end
    end
  end

  // R5: each strobe closes a group of ticks
  p_strobe_after_tick_r5: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(tick));

  // R9: strobes are single-cycle pulses
  p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int PRESC_W = 3,
  parameter int INT_W   = 16,
  parameter int FRAC_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [PRESC_W-1:0] presc_sel,
  input  logic [INT_W-1:0]   div_int,
  input  logic [FRAC_W-1:0]  div_frac,
  input  logic [1:0]         ovs_sel,
  output logic               tick,
  output logic               bit_strobe
);

  logic               run;
  logic [PRESC_W-1:0] presc_q;
  logic [INT_W-1:0]   int_q;
  logic [FRAC_W-1:0]  frac_q;
  ovs_e               ovs_q;
  logic               ce;
  logic               tick_i;

  // Settings are captured only while the block is stopped.
  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      presc_q <= '0;
      int_q   <= '0;
      frac_q  <= '0;
      ovs_q   <= OVS_X16;
    end else begin
      run <= en;
      if (!run) begin
        presc_q <= presc_sel;
        int_q   <= div_int;
        frac_q  <= div_frac;
        ovs_q   <= ovs_e'(ovs_sel);
      end
    end
  end

  bt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .presc (presc_q),
    .ce    (ce)
  );

  bt_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_frac (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .ce       (ce),
    .div_int  (int_q),
    .div_frac (frac_q),
    .tick     (tick_i)
  );

  bt_ovs_counter u_ovs (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .tick   (tick_i),
    .ovs    (ovs_q),
    .strobe (bit_strobe)
  );

  assign tick = tick_i;

  // R7: captured settings hold still while running
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> ($stable(int_q) && $stable(frac_q) && $stable(presc_q)));

  // R8: outputs idle while stopped
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (!tick && !bit_strobe));

endmodule

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [2:0]  presc_sel = '0;
  logic [15:0] div_int = '0;
  logic [5:0]  div_frac = '0;
  logic [1:0]  ovs_sel = '0;
  logic        tick;
  logic        bit_strobe;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst(rst), .en(en), .presc_sel(presc_sel), .div_int(div_int),
    .div_frac(div_frac), .ovs_sel(ovs_sel), .tick(tick), .bit_strobe(bit_strobe)
  );

  // {presc, whole, fraction, oversampling}
  localparam logic [26:0] VECS [5] = '{
    {3'd0, 16'd130, 6'd13, 2'd0},
    {3'd2, 16'd5,   6'd32, 2'd1},
    {3'd7, 16'd2,   6'd63, 2'd2},
    {3'd0, 16'd1,   6'd0,  2'd3},
    {3'd1, 16'd1,   6'd1,  2'd1}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic program_cfg(input int p, input int w, input int f, input int o);
    @(negedge clk);
    en = 1'b0; presc_sel = 3'(p); div_int = 16'(w); div_frac = 6'(f); ovs_sel = 2'(o);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_case(input int p, input int w, input int f, input int o);
    int d = p + 1;
    int n = 0;
    int last = 0;
    int t64 = -1;
    int first = -1;
    int scnt = 0;
    int bad = 0;
    int ratio = (o == 1) ? 8 : (o == 2) ? 3 : 16;
    program_cfg(p, w, f, o);
    en = 1'b1;
    for (int cyc = 1; cyc < 20000; cyc++) begin
      int t;
      @(negedge clk);
      t = cyc - 1;
      if (tick && n < 64) begin
        n++;
        if (n == 1) first = t;
        else if ((t - last) != w * d && (t - last) != (w + 1) * d) bad++;
        last = t;
        if (n == 64) t64 = t;
      end
      if (bit_strobe && (t64 < 0 || t <= t64 + 1)) scnt++;
      if (t64 >= 0 && t >= t64 + 1) break;
    end
    en = 1'b0;
    chk(first == w * d + 1, "R6/R1 first tick latency", first, w * d + 1);
    chk(bad == 0, "R2/R1 period set", bad, 0);
    chk(t64 == d * (64 * w + f) + 1, (w == 130) ? "R3 64-tick span" : "R2 64-tick span",
        t64, d * (64 * w + f) + 1);
    chk(scnt == 64 / ratio, "R5 strobe count", scnt, 64 / ratio);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!tick && !bit_strobe, "R8 reset outputs", {tick, bit_strobe}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tick && !bit_strobe, "R8 after reset release", {tick, bit_strobe}, 0);

    foreach (VECS[k]) begin
      run_case(int'(VECS[k][26:24]), int'(VECS[k][23:8]), int'(VECS[k][7:2]), int'(VECS[k][1:0]));
    end

    // R4: zero whole part with a fraction set
    begin
      int seen = 0;
      program_cfg(0, 0, 40, 2);
      en = 1'b1;
      repeat (300) begin
        @(negedge clk);
        if (tick || bit_strobe) seen++;
      end
      en = 1'b0;
      chk(seen == 0, "R4 zero whole part silent", seen, 0);
    end

    // R7: settings changed while running are ignored
    begin
      int tt[3];
      int n = 0;
      int dbl = 0;
      bit prev = 1'b0;
      program_cfg(0, 4, 0, 0);
      en = 1'b1;
      for (int cyc = 1; cyc < 200 && n < 3; cyc++) begin
        @(negedge clk);
        if (tick && prev) dbl++;
        prev = tick;
        if (tick) begin
          tt[n] = cyc - 1;
          n++;
          if (n == 1) begin
            div_int = 16'd9; div_frac = 6'd50; presc_sel = 3'd5; ovs_sel = 2'd2;
          end
        end
      end
      en = 1'b0;
      chk(tt[0] == 5, "R7 first tick before change", tt[0], 5);
      chk(tt[1] - tt[0] == 4, "R7 period after change", tt[1] - tt[0], 4);
      chk(tt[2] - tt[1] == 4, "R7 period held", tt[2] - tt[1], 4);
      chk(dbl == 0, "R9 tick single cycle", dbl, 0);
    end

    // R6: disable clears, re-enable restarts latency
    begin
      int first = -1;
      program_cfg(0, 6, 20, 1);
      en = 1'b1;
      repeat (10) @(negedge clk);
      en = 1'b0;
      repeat (3) @(negedge clk);
      chk(!tick && !bit_strobe, "R6 outputs cleared when disabled", {tick, bit_strobe}, 0);
      en = 1'b1;
      for (int cyc = 1; cyc < 100; cyc++) begin
        @(negedge clk);
        if (tick) begin
          first = cyc - 1;
          break;
        end
      end
      en = 1'b0;
      chk(first == 7, "R6 restart latency", first, 7);
    end

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule